// File: doc/BRIEF.md
# Quad-lane serial flash word engine

This block is a half-duplex serial flash master that moves exactly one word per command. Software loads up to 128 bits of transmit data into four 32-bit data slots, sets the clock enable and divider, and then writes a command word. The command word selects the operation, which fixes the lane count, and gives the word length. The engine asserts chip select, toggles the serial clock and shifts the word. A write always goes out on one lane. A read comes in on one, two or four lanes. When the last bit has gone, the engine releases chip select, drops the busy flag and raises the word-complete flag.

The four data slots together form one 128-bit word. The slot at 0x50 is the least significant and the slot at 0x70 is the most significant. A write sends the low N bits of that word, most significant bit first. A read clears the word and fills it from the bottom, so the result is right-aligned and the unused upper bits are zero. An invalidate command only clears the word-complete flag.

Top module: `qspi_word_engine`

## Requirements
- R1: While reset is asserted and afterwards until the first register write, status reads 0 and clock control reads 0. `sclk_o` is low, `cs_n_o` is high and `io_oe_o` is 0.
- R2: The engine has these registers. Clock control is at 0x40, with bit 31 as the clock enable and bits 15:0 as the divider D. Clock idle level is at 0x44, in bit 0. The data slots are at 0x50 (bits 31:0), 0x68 (63:32), 0x6C (95:64) and 0x70 (127:96). Every one of these reads back what was written to it.
- R3: A command is a write to 0x48. Bits 18:16 hold the operation: 1 is a single-lane read, 2 is a single-lane write, 3 is a dual-lane read, 7 is a quad-lane read and 4 is invalidate. Bits 25:19 hold N−1, where N is the word length from 1 to 128.
- R4: An accepted transfer command sets busy, clears word-complete and drives `cs_n_o` low, all from the following cycle. This lasts exactly 2·(D+1)·N/L cycles, where L is the lane count. At the end of that time busy falls, word-complete rises and `cs_n_o` returns high, all in the same cycle.
- R5: `sclk_o` rests at the level in 0x44 bit 0 whenever no transfer is running. Each bit group takes two half periods of D+1 cycles each. The idle half comes first, then the active half.
- R6: During a write, `io_oe_o` is 0001. `io_o[0]` carries bit N−1−k of the 128-bit word for the whole of group k. The data slots keep their contents after the write.
- R7: During a read, `io_oe_o` is 0000, and the inputs are sampled when `sclk_o` moves to its active level. A single-lane read samples `io_i[1]`. A dual-lane read samples `io_i[1:0]` and a quad-lane read samples `io_i[3:0]`, with the higher pin as the more significant bit in each case. The first group received is the most significant, and the result is right-aligned with the upper bits zero.
- R8: A command written while busy is ignored.
- R9: A command is rejected if its operation code is undefined, or if N is not a multiple of the lane count. A rejected command leaves busy and word-complete unchanged.
- R10: Invalidate starts no transfer and clears word-complete.
- R11: While the clock enable is 0, every command is ignored.
- R12: Status is read at 0x4C. Bit 0 is busy and bit 1 is word-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 8 | register byte address |
| bus_wdata | input | 32 | register write data |
| bus_rdata | output | 32 | register read data, combinational from bus_addr |
| sclk_o | output | 1 | serial clock |
| cs_n_o | output | 1 | chip select, active low |
| io_o | output | 4 | data line outputs |
| io_oe_o | output | 4 | data line output enables |
| io_i | input | 4 | data line inputs |

## Verification
A command is accepted on the clock edge that captures it. Busy, the low chip select and the first idle half all show up after that edge. The clock turns active D+1 edges later, and busy falls 2·(D+1)·N/L edges after acceptance. The bench runs a behavioural model on the same edges and measures elapsed cycles as a plain count. It compares the model against the pins at every falling clock edge, once all registers have settled. It drives read data at falling edges, so each group is steady across the sampling edge. It reads status and data slots one falling edge after a bus write, because register readback is combinational.

// File: rtl/qspi_word_pkg.sv
package qspi_word_pkg;
  localparam int REG_W  = 32;
  localparam int SLOTS  = 4;
  localparam int DIV_W  = 16;

  localparam logic [7:0] A_CLK  = 8'h40;
  localparam logic [7:0] A_IDLE = 8'h44;
  localparam logic [7:0] A_CMD  = 8'h48;
  localparam logic [7:0] A_STAT = 8'h4C;

  localparam logic [2:0] OP_RD1  = 3'd1;
  localparam logic [2:0] OP_WR1  = 3'd2;
  localparam logic [2:0] OP_RD2  = 3'd3;
  localparam logic [2:0] OP_DROP = 3'd4;
  localparam logic [2:0] OP_RD4  = 3'd7;

  localparam int OP_LSB  = 16;
  localparam int LEN_LSB = 19;

  // data slot addresses, least significant slot first
  function automatic logic [7:0] slot_addr(input int idx);
    case (idx)
      0:       return 8'h50;
      1:       return 8'h68;
      2:       return 8'h6C;
      default: return 8'h70;
    endcase
  endfunction
endpackage

// File: rtl/qspi_tick_gen.sv
module qspi_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq #(
  parameter int LEN_W = 7,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             drop,
  input  logic             tick,
  input  logic [CNT_W-1:0] nbits,
  input  logic [2:0]       step_in,
  input  logic             rd_in,
  output logic             busy,
  output logic             wc,
  output logic             phase,
  output logic             rd,
  output logic [2:0]       step,
  output logic [LEN_W-1:0] bit_idx,
  output logic             sample
);
  logic             busy_q, busy_d, wc_q, wc_d, phase_q, phase_d, rd_q, rd_d;
  logic [CNT_W-1:0] rem_q, rem_d, step_ext;
  logic [2:0]       step_q, step_d;

  assign step_ext = {{(CNT_W-3){1'b0}}, step_q};

  always_comb begin
    busy_d  = busy_q;
    wc_d    = wc_q;
    phase_d = phase_q;
    rd_d    = rd_q;
    rem_d   = rem_q;
    step_d  = step_q;
    if (start) begin
      busy_d  = 1'b1;
      wc_d    = 1'b0;
      phase_d = 1'b0;
      rem_d   = nbits;
      step_d  = step_in;
      rd_d    = rd_in;
    end else if (drop) begin
      wc_d = 1'b0;
    end else if (busy_q && tick) begin
      if (!phase_q) begin
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (rem_q == step_ext) begin
          busy_d = 1'b0;
          wc_d   = 1'b1;
          rem_d  = '0;
        end else begin
          rem_d = rem_q - step_ext;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wc_q    <= 1'b0;
      phase_q <= 1'b0;
      rd_q    <= 1'b0;
      rem_q   <= '0;
      step_q  <= 3'd1;
    end else begin
      busy_q  <= busy_d;
      wc_q    <= wc_d;
      phase_q <= phase_d;
      rd_q    <= rd_d;
      rem_q   <= rem_d;
      step_q  <= step_d;
    end
  end

  assign busy    = busy_q;
  assign wc      = wc_q;
  assign phase   = phase_q;
  assign rd      = rd_q;
  assign step    = step_q;
  assign bit_idx = LEN_W'(rem_q - 1'b1);
  assign sample  = busy_q && tick && !phase_q && rd_q;

  assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_q) |-> $fell(busy_q));
  assert_rem_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));
  assert_phase_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !phase_q);
endmodule

// File: rtl/qspi_data_bank.sv
module qspi_data_bank #(
  parameter int REG_W = 32,
  parameter int SLOTS = 4,
  localparam int WORD_W = REG_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp,
  input  logic [2:0]        step,
  input  logic [3:0]        io_i,
  input  logic [SLOTS-1:0]  slot_we,
  input  logic [REG_W-1:0]  wdata,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_we[i]) word_d[i*REG_W +: REG_W] = wdata;
    end
    if (smp) begin
      case (step)
        3'd4:    word_d = {word_q[WORD_W-5:0], io_i};
        3'd2:    word_d = {word_q[WORD_W-3:0], io_i[1:0]};
        default: word_d = {word_q[WORD_W-2:0], io_i[1]};
      endcase
    end
    if (clr) word_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word_q == '0));
endmodule

// File: rtl/qspi_word_engine.sv
module qspi_word_engine
  import qspi_word_pkg::*;
#(
  parameter int P_REG_W = REG_W,
  parameter int P_SLOTS = SLOTS,
  parameter int P_DIV_W = DIV_W,
  localparam int WORD_W = P_REG_W * P_SLOTS,
  localparam int LEN_W  = $clog2(WORD_W),
  localparam int CNT_W  = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [P_REG_W-1:0] bus_wdata,
  output logic [P_REG_W-1:0] bus_rdata,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  input  logic [3:0]         io_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // configuration registers
  logic               en_q, en_d, idle_q, idle_d;
  logic [P_DIV_W-1:0] div_q, div_d;
  logic               wr_clk, wr_idle, wr_cmd;

  assign wr_clk  = bus_wr && (bus_addr == A_CLK);
  assign wr_idle = bus_wr && (bus_addr == A_IDLE);
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);

  always_comb begin
    en_d   = wr_clk  ? bus_wdata[P_REG_W-1]   : en_q;
    div_d  = wr_clk  ? bus_wdata[P_DIV_W-1:0] : div_q;
    idle_d = wr_idle ? bus_wdata[0]           : idle_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      div_q  <= div_d;
      idle_q <= idle_d;
    end
  end

  // command decode
  logic [2:0]       op;
  logic [LEN_W-1:0] len_m1;
  logic [CNT_W-1:0] nbits;
  logic [2:0]       step_cmd;
  logic             rd_cmd, fits, take, start, drop;
  logic             busy, wc, phase, rd, tick, sample;
  logic [2:0]       step;
  logic [LEN_W-1:0] bit_idx;

  assign op     = bus_wdata[OP_LSB +: 3];
  assign len_m1 = bus_wdata[LEN_LSB +: LEN_W];
  assign nbits  = {1'b0, len_m1} + 1'b1;

  always_comb begin
    step_cmd = 3'd1;
    rd_cmd   = 1'b1;
    fits     = 1'b0;
    case (op)
      OP_RD1: fits = 1'b1;
      OP_WR1: begin rd_cmd = 1'b0; fits = 1'b1; end
      OP_RD2: begin step_cmd = 3'd2; fits = len_m1[0]; end
      OP_RD4: begin step_cmd = 3'd4; fits = &len_m1[1:0]; end
      default: fits = 1'b0;
    endcase
  end

  assign take  = wr_cmd && !busy && en_q;
  assign start = take && fits;
  assign drop  = take && (op == OP_DROP);

  qspi_tick_gen #(.DIV_W(P_DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .div(div_q), .tick(tick)
  );

  qspi_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .drop(drop), .tick(tick),
    .nbits(nbits), .step_in(step_cmd), .rd_in(rd_cmd),
    .busy(busy), .wc(wc), .phase(phase), .rd(rd), .step(step),
    .bit_idx(bit_idx), .sample(sample)
  );

  // data slots
  logic [P_SLOTS-1:0] slot_we;
  logic [WORD_W-1:0]  word;

  for (genvar g = 0; g < P_SLOTS; g++) begin : g_slot
    assign slot_we[g] = bus_wr && (bus_addr == slot_addr(g));
  end

  qspi_data_bank #(.REG_W(P_REG_W), .SLOTS(P_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .clr(start && rd_cmd), .smp(sample),
    .step(step), .io_i(io_i), .slot_we(slot_we), .wdata(bus_wdata),
    .word(word)
  );

  // register readback
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CLK:  bus_rdata = {en_q, {(P_REG_W-1-P_DIV_W){1'b0}}, div_q};
      A_IDLE: bus_rdata = {{(P_REG_W-1){1'b0}}, idle_q};
      A_STAT: bus_rdata = {{(P_REG_W-2){1'b0}}, wc, busy};
      default: begin
        for (int i = 0; i < P_SLOTS; i++) begin
          if (bus_addr == slot_addr(i)) bus_rdata = word[i*P_REG_W +: P_REG_W];
        end
      end
    endcase
  end

  // pins
  assign sclk_o  = idle_q ^ (busy && phase);
  assign cs_n_o  = !busy;
  assign io_oe_o = {3'b000, busy && !rd};
  assign io_o    = {3'b000, busy && !rd && word[bit_idx]};

  assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_q |=> !$rose(busy));
  assert_sclk_rest_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (sclk_o == idle_q));
endmodule

// File: tb/qspi_word_engine_test.sv
`timescale 1ns/1ps
module qspi_word_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk_o, cs_n_o;
  logic [3:0]  io_o, io_oe_o, io_i;

  always #2 clk = ~clk;

  qspi_word_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference model
  bit           m_busy, m_wc, m_en, m_idle, m_rd, cmp_on;
  int           m_el, m_total, m_half, m_n, m_l;
  logic [15:0]  m_div;
  logic [31:0]  m_dr [4];
  logic [127:0] m_tx, rx_pat;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int slot_of(logic [7:0] a);
    case (a)
      8'h50: return 0;
      8'h68: return 1;
      8'h6C: return 2;
      8'h70: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [127:0] low_mask(int n);
    logic [127:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  always @(posedge clk) begin : model
    bit was_busy, en_old, ok;
    int op, n, l, s;
    logic [127:0] r;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
    if (!rst_n) begin
      m_busy = 0; m_wc = 0; m_en = 0; m_idle = 0; m_rd = 0; m_div = '0;
      m_el = 0; m_total = 0; m_half = 1; m_n = 1; m_l = 1;
      for (int i = 0; i < 4; i++) m_dr[i] = '0;
    end else begin
      was_busy = m_busy;
      en_old   = m_en;
      if (m_busy) begin
        m_el++;
        if (m_el == m_total) begin
          m_busy = 0;
          m_wc   = 1;
          if (m_rd) begin
            r = rx_pat & low_mask(m_n);
            for (int i = 0; i < 4; i++) m_dr[i] = r[i*32 +: 32];
          end
        end
      end
      if (bus_wr) begin
        s = slot_of(bus_addr);
        if (bus_addr == 8'h40) begin
          m_en  = bus_wdata[31];
          m_div = bus_wdata[15:0];
        end else if (bus_addr == 8'h44) begin
          m_idle = bus_wdata[0];
        end else if (bus_addr == 8'h48 && !was_busy && en_old) begin
          op = int'(bus_wdata[18:16]);
          n  = int'(bus_wdata[25:19]) + 1;
          l  = (op == 3) ? 2 : (op == 7) ? 4 : 1;
          ok = (op == 1 || op == 2 || op == 3 || op == 7) && (n % l == 0);
          if (op == 4) m_wc = 0;
          else if (ok) begin
            m_busy = 1; m_wc = 0; m_el = 0; m_n = n; m_l = l;
            m_rd = (op != 2); m_half = int'(m_div) + 1;
            m_total = 2 * m_half * (n / l);
            m_tx = {m_dr[3], m_dr[2], m_dr[1], m_dr[0]};
          end
        end else if (s >= 0) begin
          m_dr[s] = bus_wdata;
        end
      end
    end
  end

  // pin comparison and read-data drive, away from the active edge
  always @(negedge clk) begin : pins
    int k, sh;
    logic [127:0] g;
    if (cmp_on) begin
      k = m_el / (2 * m_half);
      chk("R5 sclk", 128'(sclk_o), 128'(m_idle ^ (m_busy && ((m_el / m_half) % 2 == 1))));
      chk("R4 cs_n", 128'(cs_n_o), 128'(!m_busy));
      chk("R6 oe", 128'(io_oe_o), 128'((m_busy && !m_rd) ? 4'b0001 : 4'b0000));
      if (m_busy && !m_rd) chk("R6 io0", 128'(io_o[0]), 128'(m_tx[m_n - 1 - k]));
      if (m_busy && m_rd) begin
        sh = (m_n / m_l - 1 - k) * m_l;
        g  = (rx_pat >> sh) & low_mask(m_l);
        if (m_l == 1) io_i = {2'b00, g[0], ~g[0]};
        else          io_i = g[3:0];
      end else io_i = 4'b0000;
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read_chk(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, 128'(bus_rdata), 128'(exp));
  endtask

  function automatic logic [31:0] cmdw(int op, int n);
    return (32'(op) << 16) | (32'(n - 1) << 19);
  endfunction

  // issue a command and count cycles with chip select low
  task automatic run_cmd(string tag, int op, int n, int exp_cycles);
    int c;
    bus_write(8'h48, cmdw(op, n));
    c = 0;
    while (cs_n_o == 1'b0 && c < 20000) begin
      c++;
      @(negedge clk);
    end
    chk(tag, 128'(c), 128'(exp_cycles));
  endtask

  initial begin
    cmp_on = 0; rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; io_i = '0;
    repeat (3) @(negedge clk);
    bus_read_chk("R1 status in reset", 8'h4C, 32'h0);
    chk("R1 sclk in reset", 128'(sclk_o), 128'(0));
    chk("R1 cs_n in reset", 128'(cs_n_o), 128'(1));
    chk("R1 oe in reset", 128'(io_oe_o), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    bus_read_chk("R1 clock control after reset", 8'h40, 32'h0);

    // R11: clock disabled, command ignored
    run_cmd("R11 cycles with clock off", 2, 8, 0);
    bus_read_chk("R11 status with clock off", 8'h4C, 32'h0);

    bus_write(8'h40, 32'h8000_0001);
    bus_read_chk("R2 clock control", 8'h40, 32'h8000_0001);
    bus_write(8'h44, 32'h0);
    bus_read_chk("R2 idle level", 8'h44, 32'h0);
    bus_write(8'h50, 32'h1122_3344);
    bus_write(8'h68, 32'h5566_7788);
    bus_write(8'h6C, 32'h99AA_BBCC);
    bus_write(8'h70, 32'hDDEE_FF01);
    bus_read_chk("R2 slot 0x50", 8'h50, 32'h1122_3344);
    bus_read_chk("R2 slot 0x68", 8'h68, 32'h5566_7788);
    bus_read_chk("R2 slot 0x6C", 8'h6C, 32'h99AA_BBCC);
    bus_read_chk("R2 slot 0x70", 8'h70, 32'hDDEE_FF01);

    // R4, R6, R12: 8-bit single-lane write
    bus_write(8'h48, cmdw(2, 8));
    bus_read_chk("R12 status busy", 8'h4C, 32'h1);
    while (cs_n_o == 1'b0) @(negedge clk);
    bus_read_chk("R12 status done", 8'h4C, 32'h2);
    bus_read_chk("R6 slot kept", 8'h50, 32'h1122_3344);

    // R3: one-bit word (length field zero)
    run_cmd("R3 one-bit write cycles", 2, 1, 4);

    // R8: command while busy ignored
    bus_write(8'h48, cmdw(2, 32));
    repeat (5) @(negedge clk);
    bus_write(8'h48, cmdw(7, 32));
    while (cs_n_o == 1'b0) @(negedge clk);
    bus_read_chk("R8 slot untouched", 8'h50, 32'h1122_3344);
    bus_read_chk("R8 status", 8'h4C, 32'h2);

    // R6: full 128-bit write, divider 0
    bus_write(8'h40, 32'h8000_0000);
    run_cmd("R4 128-bit write cycles", 2, 128, 256);

    // R10: invalidate
    bus_write(8'h48, cmdw(4, 8));
    bus_read_chk("R10 invalidate clears flag", 8'h4C, 32'h0);
    chk("R10 no chip select", 128'(cs_n_o), 128'(1));

    // R9: rejected commands
    run_cmd("R4 8-bit write cycles", 2, 8, 16);
    run_cmd("R9 undefined op", 5, 8, 0);
    bus_read_chk("R9 status after op 5", 8'h4C, 32'h2);
    run_cmd("R9 dual odd length", 3, 7, 0);
    run_cmd("R9 quad length 30", 7, 30, 0);
    bus_read_chk("R9 status after misfit", 8'h4C, 32'h2);

    // R7: reads on each lane count
    bus_write(8'h40, 32'h8000_0001);
    rx_pat = 128'hA5;
    run_cmd("R4 single read cycles", 1, 8, 32);
    bus_read_chk("R7 single read", 8'h50, 32'h0000_00A5);
    bus_read_chk("R7 upper cleared", 8'h68, 32'h0);
    rx_pat = 128'hC35A;
    run_cmd("R4 dual read cycles", 3, 16, 32);
    bus_read_chk("R7 dual read", 8'h50, 32'h0000_C35A);
    rx_pat = 128'hDEAD_BEEF;
    run_cmd("R4 quad read cycles", 7, 32, 32);
    bus_read_chk("R7 quad read", 8'h50, 32'hDEAD_BEEF);
    rx_pat = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
    run_cmd("R4 quad 128 cycles", 7, 128, 128);
    bus_read_chk("R7 read 0x50", 8'h50, 32'hB4A5_9687);
    bus_read_chk("R7 read 0x68", 8'h68, 32'hF0E1_D2C3);
    bus_read_chk("R7 read 0x6C", 8'h6C, 32'h89AB_CDEF);
    bus_read_chk("R7 read 0x70", 8'h70, 32'h0123_4567);

    // R5: idle level high, divider 2
    bus_write(8'h44, 32'h1);
    bus_write(8'h40, 32'h8000_0002);
    chk("R5 idle high", 128'(sclk_o), 128'(1));
    run_cmd("R5 write cycles div 2", 2, 16, 96);

    // R11: disable again
    bus_write(8'h40, 32'h0000_0002);
    run_cmd("R11 ignored when disabled", 1, 8, 0);
    bus_read_chk("R11 status", 8'h4C, 32'h2);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule